// File: doc/BRIEF.md
# Indexed Configuration Register Window

The block sits on the CPU's I/O cycle path and gives software a two-port window into a small bank of 8-bit configuration registers. A write to the index port names a register; the next access to the data port reads or writes that register. Every I/O cycle the block sees is either served internally or flagged as a normal external I/O cycle, so that other devices behind the same two port addresses keep working.

A 4-bit map-enable field opens an extended index range; until it is set to the open code only a base range of indexes is claimed. A sticky lock bit shields the fields that control a privileged operating mode from writes issued outside that mode. One cycle is presented per clock with `io_valid_i`. Read data and the external-cycle flag are combinational for the presented cycle, and register state updates on the following clock edge.

Top module: `cfg_window`

## Requirements
- R1: An index-port write whose index is accessible is absorbed (`ext_req_o`=0) and arms the window, and the next data-port access is served internally against that index.
- R2: An armed index serves exactly one data-port access; a later data-port access with no new index write is external (`ext_req_o`=1), and a data-port read that is not served returns 0.
- R3: An index-port read is always external and leaves the armed state unchanged.
- R4: Indexes C0h-CFh and FEh-FFh are accessible whatever the map-enable field holds (bits 7:4 of the register at C3h).
- R5: Indexes 20h and D0h-FDh are accessible only while the map-enable field equals 0001b; otherwise an index write to them, or to any other index outside the base range, is external and disarms the window.
- R6: While the map-enable field equals 0001b, an index-port write of any value 00h-FFh is absorbed.
- R7: After reset all registers read zero except the recovery field (bits 2:0 of C4h), which reads 5, and FEh/FFh, which read the ID0/ID1 parameters.
- R8: While the lock bit (bit 0 of C3h) is set and `priv_i` is low, writes leave bits 3:1 of C1h, bit 1 of C3h and the whole of CDh-CFh unchanged; other bits of C1h and C3h are still written.
- R9: Writing 0 to the lock bit never clears it; only reset does.
- R10: FEh and FFh ignore writes.
- R11: Accessible indexes with no register (for example C0h, C5h, D0h) read 0 and ignore writes; implemented registers are C1h-C4h, CDh-CFh, FEh, FFh, 20h and F0h.
- R12: Cycles to any other I/O address are external and leave the armed state unchanged; with `io_valid_i` low, `ext_req_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_valid_i | input | 1 | An I/O cycle is presented this clock |
| io_addr_i | input | ADDR_W | I/O address of the cycle |
| io_write_i | input | 1 | 1 for write, 0 for read |
| io_wdata_i | input | 8 | Write data |
| priv_i | input | 1 | CPU is in the privileged mode |
| rdata_o | output | 8 | Read data for an internally served read, else 0 |
| ext_req_o | output | 1 | Cycle must run on the external bus |

## Verification
The bench builds the block with the default port addresses 22h and 23h and with ID values A5h and 3Ch, so the read-only check sees non-zero patterns that a write of zero or all ones would visibly disturb. Random index choices are drawn from a pool mixing base, extended, unimplemented and foreign indexes, and random writes to C3h reach both the open map code and the lock bit, so gating, lock protection and the privileged override meet in varied orders. A mid-run reset lets the lock be seen cleared only by reset.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned MAP_W   = 4;
  localparam int unsigned RGN_NUM = 3;

  localparam logic [REG_W-1:0] IDX_CTL1 = 8'hC1;
  localparam logic [REG_W-1:0] IDX_CTL2 = 8'hC2;
  localparam logic [REG_W-1:0] IDX_CTL3 = 8'hC3;
  localparam logic [REG_W-1:0] IDX_CTL4 = 8'hC4;
  localparam logic [REG_W-1:0] IDX_RGN0 = 8'hCD;
  localparam logic [REG_W-1:0] IDX_ID0  = 8'hFE;
  localparam logic [REG_W-1:0] IDX_ID1  = 8'hFF;
  localparam logic [REG_W-1:0] IDX_PERF = 8'h20;
  localparam logic [REG_W-1:0] IDX_PWR  = 8'hF0;

  localparam logic [MAP_W-1:0] MAP_OPEN = 4'b0001;

  typedef enum logic [1:0] {
    CYC_OTHER = 2'd0,
    CYC_INDEX = 2'd1,
    CYC_DATA  = 2'd2
  } cyc_kind_e;

  function automatic logic in_base_range(input logic [REG_W-1:0] idx);
    return (idx[7:4] == 4'hC) || (idx[7:1] == 7'h7F);
  endfunction
endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
  import cfg_window_pkg::*;
(
  input  logic [REG_W-1:0] idx_i,
  input  logic [MAP_W-1:0] map_i,
  output logic             accessible_o
);
  // open map claims the whole index space; otherwise only the base range
  always_comb accessible_o = in_base_range(idx_i) || (map_i == MAP_OPEN);
endmodule

// File: rtl/cfg_arm_tracker.sv
module cfg_arm_tracker
  import cfg_window_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] idx_i,
  output logic             armed_o,
  output logic [REG_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      idx_o   <= '0;
    end else if (set_i) begin
      armed_o <= 1'b1;
      idx_o   <= idx_i;
    end else if (clr_i) begin
      armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_window_pkg::*;
#(
  parameter logic [REG_W-1:0] ID0      = 8'h2D,
  parameter logic [REG_W-1:0] ID1      = 8'h12,
  parameter logic [2:0]       RECOV_RST = 3'd5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             priv_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [MAP_W-1:0] map_o,
  output logic             lock_o
);
  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, perf_q, pwr_q;
  logic [REG_W-1:0] rgn_q [RGN_NUM];
  logic             guard;

  assign guard  = ctl3_q[0] && !priv_i;
  assign map_o  = ctl3_q[7:4];
  assign lock_o = ctl3_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      ctl2_q <= '0;
      ctl3_q <= '0;
      ctl4_q <= {{(REG_W-3){1'b0}}, RECOV_RST};
      perf_q <= '0;
      pwr_q  <= '0;
    end else if (wr_en_i) begin
      unique case (idx_i)
        IDX_CTL1: ctl1_q <= guard ? {wdata_i[7:4], ctl1_q[3:1], wdata_i[0]} : wdata_i;
        IDX_CTL2: ctl2_q <= wdata_i;
        IDX_CTL3: ctl3_q <= {wdata_i[7:2], guard ? ctl3_q[1] : wdata_i[1],
                             ctl3_q[0] | wdata_i[0]};
        IDX_CTL4: ctl4_q <= wdata_i;
        IDX_PERF: perf_q <= wdata_i;
        IDX_PWR:  pwr_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < RGN_NUM; g++) begin : g_rgn
    localparam logic [REG_W-1:0] MY_IDX = IDX_RGN0 + REG_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    rgn_q[g] <= '0;
      else if (wr_en_i && idx_i == MY_IDX && !guard)  rgn_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_CTL1: rdata_o = ctl1_q;
      IDX_CTL2: rdata_o = ctl2_q;
      IDX_CTL3: rdata_o = ctl3_q;
      IDX_CTL4: rdata_o = ctl4_q;
      IDX_PERF: rdata_o = perf_q;
      IDX_PWR:  rdata_o = pwr_q;
      IDX_ID0:  rdata_o = ID0;
      IDX_ID1:  rdata_o = ID1;
      default: begin
        for (int k = 0; k < RGN_NUM; k++)
          if (idx_i == IDX_RGN0 + REG_W'(k)) rdata_o = rgn_q[k];
      end
    endcase
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023,
  parameter logic [7:0]       ID0        = 8'h2D,
  parameter logic [7:0]       ID1        = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_valid_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_write_i,
  input  logic [7:0]        io_wdata_i,
  input  logic              priv_i,
  output logic [7:0]        rdata_o,
  output logic              ext_req_o
);
  cyc_kind_e        kind;
  logic             idx_ok, idx_take, idx_reject, data_take;
  logic             armed;
  logic [REG_W-1:0] arm_idx, bank_rdata;
  logic [MAP_W-1:0] map;
  logic             lock;

  always_comb begin
    kind = CYC_OTHER;
    if (io_valid_i && io_addr_i == INDEX_PORT)     kind = CYC_INDEX;
    else if (io_valid_i && io_addr_i == DATA_PORT) kind = CYC_DATA;
  end

  cfg_index_decode i_decode (
    .idx_i        (io_wdata_i),
    .map_i        (map),
    .accessible_o (idx_ok)
  );

  assign idx_take   = (kind == CYC_INDEX) && io_write_i && idx_ok;
  assign idx_reject = (kind == CYC_INDEX) && io_write_i && !idx_ok;
  assign data_take  = (kind == CYC_DATA) && armed;

  cfg_arm_tracker i_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (idx_take),
    .clr_i   (idx_reject || kind == CYC_DATA),
    .idx_i   (io_wdata_i),
    .armed_o (armed),
    .idx_o   (arm_idx)
  );

  cfg_reg_bank #(.ID0(ID0), .ID1(ID1)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (data_take && io_write_i),
    .idx_i   (arm_idx),
    .wdata_i (io_wdata_i),
    .priv_i  (priv_i),
    .rdata_o (bank_rdata),
    .map_o   (map),
    .lock_o  (lock)
  );

  assign ext_req_o = io_valid_i && !(idx_take || data_take);
  assign rdata_o   = (data_take && !io_write_i) ? bank_rdata : '0;
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h0022,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h0023
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_valid_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_write_i,
  input logic              priv_i,
  input logic [7:0]        rdata_o,
  input logic              ext_req_o,
  input logic              armed,
  input logic [7:0]        arm_idx,
  input logic [3:0]        map,
  input logic              lock,
  input logic [7:0]        ctl1
);
  a_r3_index_read_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && io_addr_i == INDEX_PORT && !io_write_i |-> ext_req_o);

  a_r2_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && io_addr_i == DATA_PORT |=> !armed);

  a_r6_open_map_absorbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && io_addr_i == INDEX_PORT && io_write_i && map == 4'b0001 |-> !ext_req_o);

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock);

  a_r8_ctl1_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && io_addr_i == DATA_PORT && io_write_i && armed && arm_idx == 8'hC1
    && lock && !priv_i |=> $stable(ctl1[3:1]));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_valid_i |-> !ext_req_o && rdata_o == 8'h00);
endmodule

bind cfg_window cfg_window_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_valid_i (io_valid_i),
  .io_addr_i  (io_addr_i),
  .io_write_i (io_write_i),
  .priv_i     (priv_i),
  .rdata_o    (rdata_o),
  .ext_req_o  (ext_req_o),
  .armed      (armed),
  .arm_idx    (arm_idx),
  .map        (map),
  .lock       (lock),
  .ctl1       (i_bank.ctl1_q)
);

// File: tb/test_cfg_window.sv
`timescale 1ns/1ps
module test_cfg_window;
  localparam logic [15:0] IP = 16'h0022;
  localparam logic [15:0] DP = 16'h0023;
  localparam logic [7:0]  ID0 = 8'hA5;
  localparam logic [7:0]  ID1 = 8'h3C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_valid_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_write_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic        priv_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        ext_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  cfg_window #(.ID0(ID0), .ID1(ID1)) i_cfg_window (.*);

  // reference model state
  logic [7:0] m_reg [0:255];
  bit         m_arm;
  logic [7:0] m_idx;

  function automatic bit m_base(input logic [7:0] x);
    return (x[7:4] == 4'hC) || (x >= 8'hFE);
  endfunction

  function automatic bit m_impl(input logic [7:0] x);
    return (x >= 8'hC1 && x <= 8'hC4) || (x >= 8'hCD && x <= 8'hCF) ||
           x == 8'hFE || x == 8'hFF || x == 8'h20 || x == 8'hF0;
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 256; k++) m_reg[k] = 8'h00;
    m_reg[8'hC4] = 8'h05;
    m_reg[8'hFE] = ID0;
    m_reg[8'hFF] = ID1;
    m_arm = 0;
    m_idx = 8'h00;
  endtask

  task automatic m_write(input logic [7:0] x, input logic [7:0] d, input bit pv);
    bit g;
    g = m_reg[8'hC3][0] && !pv;
    if (!m_impl(x) || x == 8'hFE || x == 8'hFF) return;
    if (x == 8'hC1)      m_reg[x] = g ? {d[7:4], m_reg[x][3:1], d[0]} : d;
    else if (x == 8'hC3) m_reg[x] = {d[7:2], g ? m_reg[x][1] : d[1], m_reg[x][0] | d[0]};
    else if (x >= 8'hCD && x <= 8'hCF) begin
      if (!g) m_reg[x] = d;
    end else m_reg[x] = d;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one I/O cycle: drive after negedge, sample before posedge, update model
  task automatic io(input logic [15:0] a, input bit wr, input logic [7:0] d,
                    input bit pv, input string req);
    bit         e_ext;
    logic [7:0] e_rd;
    e_ext = 1; e_rd = 8'h00;
    if (a == IP) begin
      if (wr) begin
        e_ext = !(m_base(d) || m_reg[8'hC3][7:4] == 4'b0001);
        m_arm = !e_ext;
        m_idx = d;
      end
    end else if (a == DP) begin
      if (m_arm) begin
        e_ext = 0;
        if (!wr) e_rd = m_reg[m_idx];
        else     m_write(m_idx, d, pv);
      end
      m_arm = 0;
    end
    io_valid_i = 1; io_addr_i = a; io_write_i = wr; io_wdata_i = d; priv_i = pv;
    #2;
    check({req, " ext"}, {7'd0, ext_req_o}, {7'd0, e_ext});
    if (!wr) check({req, " rdata"}, rdata_o, e_rd);
    @(posedge clk_i);
    @(negedge clk_i);
    io_valid_i = 0;
  endtask

  task automatic rd_reg(input logic [7:0] x, input string req);
    io(IP, 1, x, 0, req);
    io(DP, 0, 8'h00, 0, req);
  endtask

  task automatic wr_reg(input logic [7:0] x, input logic [7:0] d, input bit pv, input string req);
    io(IP, 1, x, pv, req);
    io(DP, 1, d, pv, req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    m_reset();
    #12;
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [16];
    void'($urandom(32'd4242));
    pool = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hCD, 8'hCE, 8'hCF, 8'hFE,
             8'hFF, 8'h20, 8'hF0, 8'hC0, 8'hC7, 8'hD3, 8'h05, 8'hC3};
    do_reset();

    // R12: idle and foreign cycles
    #2;
    check("R12 idle ext", {7'd0, ext_req_o}, 8'h00);
    check("R12 idle rdata", rdata_o, 8'h00);
    @(negedge clk_i);

    // R7: reset values
    rd_reg(8'hC4, "R7 recovery reset");
    rd_reg(8'hC3, "R7 ctl3 reset");
    rd_reg(8'hCD, "R7 region reset");
    rd_reg(8'hFE, "R7 id0");
    rd_reg(8'hFF, "R7 id1");

    // R1/R2: one-shot arming
    wr_reg(8'hC2, 8'h5A, 0, "R1 write");
    io(DP, 0, 8'h00, 0, "R2 second access external");
    rd_reg(8'hC2, "R1 readback");
    io(IP, 1, 8'hC2, 0, "R12 arm");
    io(16'h0080, 1, 8'h11, 0, "R12 foreign keeps arm");
    io(IP, 0, 8'h00, 0, "R3 index read external");
    io(DP, 0, 8'h00, 0, "R3 arm kept after index read");

    // R5/R4: extended range gated
    io(IP, 1, 8'h20, 0, "R5 closed ext index");
    io(DP, 1, 8'hFF, 0, "R5 data not served");
    io(IP, 1, 8'h05, 0, "R5 foreign index");
    wr_reg(8'hC3, 8'h10, 0, "R4 open map");
    wr_reg(8'h20, 8'h81, 0, "R6 perf write");
    rd_reg(8'h20, "R6 perf read");
    io(IP, 1, 8'h07, 0, "R6 any index absorbed");
    io(DP, 0, 8'h00, 0, "R11 unimpl reads zero");
    wr_reg(8'hC1, 8'hFF, 0, "R4 ctl1 open");
    rd_reg(8'hC1, "R4 ctl1 read");
    wr_reg(8'hC3, 8'h00, 0, "R4 close map");
    rd_reg(8'hC1, "R4 base reachable closed");
    io(IP, 1, 8'hF0, 0, "R5 closed pwr index");

    // R10/R11
    wr_reg(8'hFE, 8'h00, 0, "R10 id0 write");
    rd_reg(8'hFE, "R10 id0 unchanged");
    wr_reg(8'hFF, 8'hFF, 0, "R10 id1 write");
    rd_reg(8'hFF, "R10 id1 unchanged");
    wr_reg(8'hC5, 8'h77, 0, "R11 unimpl write");
    rd_reg(8'hC5, "R11 unimpl zero");

    // R8/R9: lock
    wr_reg(8'hCD, 8'h12, 0, "R8 region pre");
    wr_reg(8'hC3, 8'h03, 0, "R8 set lock");
    wr_reg(8'hC1, 8'h00, 0, "R8 guarded ctl1");
    rd_reg(8'hC1, "R8 ctl1 bits kept");
    wr_reg(8'hCD, 8'h99, 0, "R8 guarded region");
    rd_reg(8'hCD, "R8 region kept");
    wr_reg(8'hC3, 8'hE0, 0, "R9 try clear lock");
    rd_reg(8'hC3, "R9 lock stays");
    wr_reg(8'hCD, 8'h44, 1, "R8 priv override");
    rd_reg(8'hCD, "R8 priv write landed");
    do_reset();
    rd_reg(8'hC3, "R9 reset clears lock");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [7:0]  x;
      r = $urandom % 10;
      x = (($urandom % 4) == 0) ? 8'($urandom) : pool[$urandom % 16];
      if (r < 4)      io(IP, 1, x, 1'($urandom), "R1 rnd index");
      else if (r < 8) io(DP, 1'($urandom), 8'($urandom), 1'($urandom), "R2 rnd data");
      else if (r < 9) io(IP, 0, 8'h00, 0, "R3 rnd index read");
      else            io(16'($urandom), 1'($urandom), 8'($urandom), 0, "R12 rnd foreign");
      if (i == 2000) do_reset();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule